// File: doc/BRIEF.md
# Adjustable 24-Hour Timekeeper with Alarm Setting

This block keeps the time of day as binary-coded decimal digits: seconds and minutes each as a units digit (0 to 9) and a tens digit (0 to 5), and hours as a units digit and a tens digit (0 to 2) covering 00 to 23. A free-running divider turns the fast input clock, nominally about 1024 Hz, into a one-cycle tick once every 2**DIV_BITS clocks. All counters run on the input clock and move only on that tick.

A single mode switch selects what two active-low push buttons act on. With the switch low, a held minute or hour button advances the running minutes or hours by one on every tick. With the switch high, the same buttons advance a separate alarm minute/hour setting instead, and the running time keeps counting on its own. A separate active-low button clears only the two seconds digits, at once and without waiting for the clock. Its release is synchronized to the clock, as is the release of the power-on reset.

The block drives the running time digits, the alarm digits and the tick. Debouncing of the buttons and any display driving are done elsewhere.

Top module: `tod_keeper`

## Requirements
- R1: While `rst_n` is low, and after it is released, every time digit and every alarm digit reads zero until the first tick moves them, and `sec_tick` stays low.
- R2: `sec_tick` is high for exactly one clock in every 2**DIV_BITS clocks. The first pulse comes 2**DIV_BITS + 1 clocks after the first rising edge at which `rst_n` is seen high.
- R3: On each tick the seconds advance by one, from 00 to 59 and then back to 00. The units digit wraps 9 to 0 and carries into the tens digit.
- R4: Without buttons, the minutes advance on the tick where the seconds go from 59 to 00. The hours advance only on the tick where the seconds and minutes are both 59. Hours run 00 to 23 and then 00, with `hr_tens` as 0, 1 or 2.
- R5: With `mode_alarm` = 0 and `min_btn_n` = 0 at a tick, the running minutes advance by one on that tick. A step from 59 to 00 made this way does not move the hours.
- R6: With `mode_alarm` = 0 and `hr_btn_n` = 0 at a tick, the running hours advance by one on that tick, 23 wrapping to 00. The minutes and seconds are not changed by this.
- R7: With `mode_alarm` = 1, the buttons advance the alarm minutes or hours instead of the running time. The alarm minutes wrap 59 to 00 without moving the alarm hours. The alarm digits change on no other occasion.
- R8: While `sec_clr_n` is low, the seconds read 00 at once, and they stay 00 for two clocks after it is released before counting resumes. The minutes, hours and alarm digits are not touched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock (about 1024 Hz) |
| rst_n | input | 1 | Power-on reset, active low, asserted asynchronously |
| mode_alarm | input | 1 | 0: buttons adjust running time, 1: buttons set alarm |
| min_btn_n | input | 1 | Minute button, active low, debounced |
| hr_btn_n | input | 1 | Hour button, active low, debounced |
| sec_clr_n | input | 1 | Seconds clear button, active low, asynchronous |
| sec_tick | output | 1 | One-cycle pulse per second |
| sec_ones | output | 4 | Seconds units, 0 to 9 |
| sec_tens | output | 3 | Seconds tens, 0 to 5 |
| min_ones | output | 4 | Minutes units, 0 to 9 |
| min_tens | output | 3 | Minutes tens, 0 to 5 |
| hr_ones | output | 4 | Hours units, 0 to 9 |
| hr_tens | output | 2 | Hours tens, 0 to 2 |
| al_min_ones | output | 4 | Alarm minutes units |
| al_min_tens | output | 3 | Alarm minutes tens |
| al_hr_ones | output | 4 | Alarm hours units |
| al_hr_tens | output | 2 | Alarm hours tens |

## Verification
The assertions check, on every cycle, the properties that hold locally. Digits stay inside their ranges, and the tick is never high two cycles in a row. The time and alarm digits hold still between ticks. The alarm digits move only when the switch and a button call for it. An hour press always moves the hours, and a minute press at 59 does not. The bench scenarios show the parts that need history: the tick spacing measured from reset, the carry chain up to 23:59:59 and its wrap to 00:00:00, the full wraps of the minute and hour adjustments, and the synchronized release of the seconds clear. These are checked against a behavioural model on every clock.

// File: rtl/tk_pkg.sv
package tk_pkg;
  localparam int UNITS_W    = 4;
  localparam int TENS60_W   = 3;
  localparam int HR_TENS_W  = 2;
  localparam int LAST_UNITS = 9;
  localparam int LAST_TENS  = 5;
  localparam int LAST_HOUR  = 23;
  localparam int BANKS      = 2;

  typedef enum logic {
    ADJ_RUN   = 1'b0,
    ADJ_ALARM = 1'b1
  } adj_target_e;
endpackage

// File: rtl/tk_rst_sync.sv
module tk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe_q <= '0;
    else         pipe_q <= pipe_d;
  end

  assign srst_n = pipe_q[STAGES-1];
endmodule

// File: rtl/tk_tick_div.sv
module tk_tick_div #(
  parameter int DIV_BITS = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  logic [DIV_BITS-1:0] cnt_q;
  logic [DIV_BITS-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = &cnt_q;
endmodule

// File: rtl/tk_digit.sv
module tk_digit #(
  parameter int W    = 4,
  parameter int LAST = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  output logic [W-1:0] value,
  output logic         at_last
);
  logic [W-1:0] val_q;
  logic [W-1:0] val_d;

  assign at_last = (val_q == W'(LAST));

  always_comb begin
    val_d = val_q;
    if (en) val_d = at_last ? '0 : val_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  assign value = val_q;
endmodule

// File: rtl/tk_hour24.sv
module tk_hour24
  import tk_pkg::*;
#(
  parameter int LAST = LAST_HOUR
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  output logic [UNITS_W-1:0]   ones,
  output logic [HR_TENS_W-1:0] tens
);
  localparam logic [UNITS_W-1:0]   LAST_O = UNITS_W'(LAST % 10);
  localparam logic [HR_TENS_W-1:0] LAST_T = HR_TENS_W'(LAST / 10);

  logic [UNITS_W-1:0]   ones_q, ones_d;
  logic [HR_TENS_W-1:0] tens_q, tens_d;
  logic                 day_end;
  logic                 ones_end;

  assign day_end  = (tens_q == LAST_T) && (ones_q == LAST_O);
  assign ones_end = (ones_q == UNITS_W'(LAST_UNITS));

  always_comb begin
    ones_d = ones_q;
    tens_d = tens_q;
    if (en) begin
      if (day_end) begin
        ones_d = '0;
        tens_d = '0;
      end else if (ones_end) begin
        ones_d = '0;
        tens_d = tens_q + 1'b1;
      end else begin
        ones_d = ones_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= '0;
      tens_q <= '0;
    end else begin
      ones_q <= ones_d;
      tens_q <= tens_d;
    end
  end

  assign ones = ones_q;
  assign tens = tens_q;
endmodule

// File: rtl/tod_keeper.sv
module tod_keeper
  import tk_pkg::*;
#(
  parameter int DIV_BITS    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_alarm,
  input  logic                 min_btn_n,
  input  logic                 hr_btn_n,
  input  logic                 sec_clr_n,
  output logic                 sec_tick,
  output logic [UNITS_W-1:0]   sec_ones,
  output logic [TENS60_W-1:0]  sec_tens,
  output logic [UNITS_W-1:0]   min_ones,
  output logic [TENS60_W-1:0]  min_tens,
  output logic [UNITS_W-1:0]   hr_ones,
  output logic [HR_TENS_W-1:0] hr_tens,
  output logic [UNITS_W-1:0]   al_min_ones,
  output logic [TENS60_W-1:0]  al_min_tens,
  output logic [UNITS_W-1:0]   al_hr_ones,
  output logic [HR_TENS_W-1:0] al_hr_tens
);
  // bank 0 = running time, bank 1 = alarm setting
  localparam int RUN = 0;
  localparam int ALM = 1;

  logic core_rst_n;
  logic sec_arst_n;
  logic sec_rst_n;
  logic tick;

  logic so_last, st_last, sec_at_59;
  logic min_key, hr_key;
  adj_target_e target;

  logic [BANKS-1:0] min_step;
  logic [BANKS-1:0] hr_step;
  logic [BANKS-1:0] mo_last;
  logic [BANKS-1:0] mt_last;
  logic [BANKS-1:0][UNITS_W-1:0]   mo_v;
  logic [BANKS-1:0][TENS60_W-1:0]  mt_v;
  logic [BANKS-1:0][UNITS_W-1:0]   ho_v;
  logic [BANKS-1:0][HR_TENS_W-1:0] ht_v;

  // reset release paths: whole block, and seconds only
  assign sec_arst_n = rst_n & sec_clr_n;

  tk_rst_sync #(.STAGES(SYNC_STAGES)) u_core_sync (
    .clk(clk), .arst_n(rst_n), .srst_n(core_rst_n)
  );

  tk_rst_sync #(.STAGES(SYNC_STAGES)) u_sec_sync (
    .clk(clk), .arst_n(sec_arst_n), .srst_n(sec_rst_n)
  );

  tk_tick_div #(.DIV_BITS(DIV_BITS)) u_div (
    .clk(clk), .rst_n(core_rst_n), .tick(tick)
  );

  // seconds
  tk_digit #(.W(UNITS_W), .LAST(LAST_UNITS)) u_sec_o (
    .clk(clk), .rst_n(sec_rst_n), .en(tick),
    .value(sec_ones), .at_last(so_last)
  );

  tk_digit #(.W(TENS60_W), .LAST(LAST_TENS)) u_sec_t (
    .clk(clk), .rst_n(sec_rst_n), .en(tick & so_last),
    .value(sec_tens), .at_last(st_last)
  );

  assign sec_at_59 = so_last & st_last;

  // step enables
  assign target  = adj_target_e'(mode_alarm);
  assign min_key = ~min_btn_n;
  assign hr_key  = ~hr_btn_n;

  always_comb begin
    min_step[RUN] = tick & (((target == ADJ_RUN) & min_key) | sec_at_59);
    hr_step[RUN]  = tick & (((target == ADJ_RUN) & hr_key)
                            | (sec_at_59 & mo_last[RUN] & mt_last[RUN]));
    min_step[ALM] = tick & (target == ADJ_ALARM) & min_key;
    hr_step[ALM]  = tick & (target == ADJ_ALARM) & hr_key;
  end

  // minute and hour counters, one set per bank
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    tk_digit #(.W(UNITS_W), .LAST(LAST_UNITS)) u_min_o (
      .clk(clk), .rst_n(core_rst_n), .en(min_step[b]),
      .value(mo_v[b]), .at_last(mo_last[b])
    );

    tk_digit #(.W(TENS60_W), .LAST(LAST_TENS)) u_min_t (
      .clk(clk), .rst_n(core_rst_n), .en(min_step[b] & mo_last[b]),
      .value(mt_v[b]), .at_last(mt_last[b])
    );

    tk_hour24 #(.LAST(LAST_HOUR)) u_hour (
      .clk(clk), .rst_n(core_rst_n), .en(hr_step[b]),
      .ones(ho_v[b]), .tens(ht_v[b])
    );
  end

  assign sec_tick    = tick;
  assign min_ones    = mo_v[RUN];
  assign min_tens    = mt_v[RUN];
  assign hr_ones     = ho_v[RUN];
  assign hr_tens     = ht_v[RUN];
  assign al_min_ones = mo_v[ALM];
  assign al_min_tens = mt_v[ALM];
  assign al_hr_ones  = ho_v[ALM];
  assign al_hr_tens  = ht_v[ALM];
endmodule

// File: rtl/tk_keeper_chk.sv
module tk_keeper_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sec_clr_n,
  input logic       mode_alarm,
  input logic       min_btn_n,
  input logic       hr_btn_n,
  input logic       sec_tick,
  input logic [3:0] sec_ones,
  input logic [2:0] sec_tens,
  input logic [3:0] min_ones,
  input logic [2:0] min_tens,
  input logic [3:0] hr_ones,
  input logic [1:0] hr_tens,
  input logic [3:0] al_min_ones,
  input logic [2:0] al_min_tens,
  input logic [3:0] al_hr_ones,
  input logic [1:0] al_hr_tens
);
  logic [4:0] hr_val;
  logic [4:0] al_hr_val;
  logic       min_at_59;
  logic       sec_at_59;

  assign hr_val    = 5'(hr_tens) * 5'd10 + 5'(hr_ones);
  assign al_hr_val = 5'(al_hr_tens) * 5'd10 + 5'(al_hr_ones);
  assign min_at_59 = (min_tens == 3'd5) && (min_ones == 4'd9);
  assign sec_at_59 = (sec_tens == 3'd5) && (sec_ones == 4'd9);

  // R2
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);

  // R3
  sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_ones <= 4'd9) && (sec_tens <= 3'd5));

  // R4
  hour_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hr_ones <= 4'd9) && (hr_val <= 5'd23) && (al_hr_ones <= 4'd9) && (al_hr_val <= 5'd23));

  // R3
  sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !sec_clr_n)
    !sec_tick |=> $stable({sec_tens, sec_ones}));

  // R4
  time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> $stable({hr_tens, hr_ones, min_tens, min_ones}));

  // R5
  min_wrap_no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !mode_alarm && !min_btn_n && hr_btn_n && min_at_59 && !sec_at_59)
    |=> $stable({hr_tens, hr_ones}));

  // R6
  hour_press_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !mode_alarm && !hr_btn_n) |=> !$stable({hr_tens, hr_ones}));

  // R7
  alarm_min_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sec_tick && mode_alarm && !min_btn_n) |=> $stable({al_min_tens, al_min_ones}));

  // R7
  alarm_hr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sec_tick && mode_alarm && !hr_btn_n) |=> $stable({al_hr_tens, al_hr_ones}));

  // R8
  sec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_clr_n |-> (sec_ones == 4'd0) && (sec_tens == 3'd0));
endmodule

bind tod_keeper tk_keeper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sec_clr_n(sec_clr_n), .mode_alarm(mode_alarm),
  .min_btn_n(min_btn_n), .hr_btn_n(hr_btn_n), .sec_tick(sec_tick),
  .sec_ones(sec_ones), .sec_tens(sec_tens), .min_ones(min_ones), .min_tens(min_tens),
  .hr_ones(hr_ones), .hr_tens(hr_tens), .al_min_ones(al_min_ones),
  .al_min_tens(al_min_tens), .al_hr_ones(al_hr_ones), .al_hr_tens(al_hr_tens)
);

// File: tb/tb_tod_keeper.sv
`timescale 1ns/1ps
module tb_tod_keeper;
  localparam int DIV_BITS = 4;
  localparam int DIV      = 1 << DIV_BITS;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n, mode_alarm, min_btn_n, hr_btn_n, sec_clr_n;
  logic       sec_tick;
  logic [3:0] sec_ones, min_ones, hr_ones, al_min_ones, al_hr_ones;
  logic [2:0] sec_tens, min_tens, al_min_tens;
  logic [1:0] hr_tens, al_hr_tens;

  tod_keeper #(.DIV_BITS(DIV_BITS)) dut (
    .clk(clk), .rst_n(rst_n), .mode_alarm(mode_alarm), .min_btn_n(min_btn_n),
    .hr_btn_n(hr_btn_n), .sec_clr_n(sec_clr_n), .sec_tick(sec_tick),
    .sec_ones(sec_ones), .sec_tens(sec_tens), .min_ones(min_ones), .min_tens(min_tens),
    .hr_ones(hr_ones), .hr_tens(hr_tens), .al_min_ones(al_min_ones),
    .al_min_tens(al_min_tens), .al_hr_ones(al_hr_ones), .al_hr_tens(al_hr_tens)
  );

  always #4 clk = ~clk;  // 125 MHz

  // reference model state
  int ref_sec, ref_min, ref_hr, ref_amin, ref_ahr;
  int ref_div, core_rel, sec_rel;
  int vectors = 0, errors = 0, cycles = 0;
  string cur_req = "R1";
  bit done = 0;

  task automatic chk(input string req, input string name, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit exp_tick, sec_in_rst, c59, madv, hadv;
    cycles++;
    if (!rst_n) begin
      ref_sec = 0; ref_min = 0; ref_hr = 0; ref_amin = 0; ref_ahr = 0;
      ref_div = 0; core_rel = 0; sec_rel = 0;
    end
    if (!sec_clr_n) begin
      ref_sec = 0; sec_rel = 0;
    end
    exp_tick = rst_n && core_rel >= 2 && ref_div == DIV - 1;
    if (!done) begin
      chk("R2", "sec_tick", int'(sec_tick), int'(exp_tick));
      chk(cur_req, "seconds", int'(sec_tens) * 10 + int'(sec_ones), ref_sec);
      chk(cur_req, "minutes", int'(min_tens) * 10 + int'(min_ones), ref_min);
      chk(cur_req, "hr_tens", int'(hr_tens), ref_hr / 10);
      chk(cur_req, "hr_ones", int'(hr_ones), ref_hr % 10);
      chk(cur_req, "al_minutes", int'(al_min_tens) * 10 + int'(al_min_ones), ref_amin);
      chk(cur_req, "al_hr_tens", int'(al_hr_tens), ref_ahr / 10);
      chk(cur_req, "al_hr_ones", int'(al_hr_ones), ref_ahr % 10);
    end
    sec_in_rst = !sec_clr_n || sec_rel < 2;
    if (rst_n) begin
      if (core_rel < 2) core_rel++;
      else begin
        ref_div = (ref_div + 1) % DIV;
        if (exp_tick) begin
          c59  = !sec_in_rst && ref_sec == 59;
          madv = (!mode_alarm && !min_btn_n) || c59;
          hadv = (!mode_alarm && !hr_btn_n) || (c59 && ref_min == 59);
          if (madv) ref_min = (ref_min + 1) % 60;
          if (hadv) ref_hr = (ref_hr + 1) % 24;
          if (mode_alarm && !min_btn_n) ref_amin = (ref_amin + 1) % 60;
          if (mode_alarm && !hr_btn_n)  ref_ahr = (ref_ahr + 1) % 24;
          if (!sec_in_rst) ref_sec = (ref_sec + 1) % 60;
        end
      end
      if (sec_clr_n && sec_rel < 2) sec_rel++;
    end
    if (cycles > WATCHDOG && !done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    rst_n = 0; mode_alarm = 0; min_btn_n = 1; hr_btn_n = 1; sec_clr_n = 1;
    // R1: reset state observed during and after reset
    cur_req = "R1";
    cyc(3);
    rst_n = 1;
    cyc(DIV);
    // R3: free running seconds, carry into minutes (R4 carry)
    cur_req = "R3";
    cyc(70 * DIV);
    // R5: minute adjust in run mode, wraps 59->00 without hour carry
    cur_req = "R5";
    min_btn_n = 0;
    cyc(65 * DIV);
    min_btn_n = 1;
    // R6: hour adjust in run mode, 23->00 wrap
    cur_req = "R6";
    hr_btn_n = 0;
    cyc(26 * DIV);
    hr_btn_n = 1;
    // R7: alarm set mode, running time unaffected by buttons
    cur_req = "R7";
    mode_alarm = 1;
    min_btn_n = 0;
    cyc(62 * DIV);
    min_btn_n = 1;
    hr_btn_n = 0;
    cyc(25 * DIV);
    min_btn_n = 0;
    cyc(3 * DIV);
    hr_btn_n = 1; min_btn_n = 1;
    mode_alarm = 0;
    // R4: drive time to 23:59 then let the day roll over
    cur_req = "R4";
    hr_btn_n = 0;
    while (ref_hr != 23) cyc(1);
    hr_btn_n = 1;
    min_btn_n = 0;
    while (ref_min != 59) cyc(1);
    min_btn_n = 1;
    cyc(65 * DIV);
    // R8: seconds-only clear, asserted mid-count, released, then again
    cur_req = "R8";
    cyc(7 * DIV + 5);
    sec_clr_n = 0;
    cyc(3 * DIV + 3);
    sec_clr_n = 1;
    cyc(5 * DIV + 1);
    sec_clr_n = 0;
    cyc(2);
    sec_clr_n = 1;
    cyc(70 * DIV);
    // R1: reset again mid-run returns all to zero
    cur_req = "R1";
    rst_n = 0;
    cyc(4);
    rst_n = 1;
    cyc(3 * DIV);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule